// File: doc/BRIEF.md
# Three-Channel Interval Timer

This block holds three independent 16-bit down counters behind a byte-wide CPU port. Two address bits pick one of three counter data ports (0 to 2) or the control port (3). A byte written to the control port picks a channel and either snapshots that channel's count into a holding latch, or sets how the channel's data port is accessed, which waveform it generates and whether it counts in binary or BCD.

Software writes a reload value one byte at a time through the channel's data port. It reads the latched count back the same way. Each counter moves only on cycles where the shared `tick_i` enable is high. This lets one fast system clock drive a slow counting rate. Each channel drives one output. In rate-generator mode the output gives a one-tick low pulse once per period. In square-wave mode it gives a 50% duty waveform.

Top module: `interval_timer`

## Requirements
- R1: A control write (address 3) uses bits [7:6] as the channel (0 to 2). A value of 3 affects no channel. When bits [5:4] are nonzero, bits [5:4] set the access mode (1 low byte only, 2 high byte only, 3 low then high), bits [3:1] set the operating mode and bit 0 sets BCD. Such a write also stops that channel and drives its output high.
- R2: In low-only access, a data write replaces reload bits [7:0]. In high-only access, it replaces bits [15:8]. The other byte is kept.
- R3: Every control write to a channel clears its byte pointer. In low-then-high access, each data read and each data write flips the pointer. Pointer 0 addresses the low byte and pointer 1 the high byte. Reads and writes share the same pointer.
- R4: A control write with bits [5:4] = 0 copies the channel's current count into its holding latch and leaves the access mode unchanged. Data reads return bytes of that latch, chosen by the access mode. The latch changes only on a latch command.
- R5: The reload value is loaded into the counter on the first tick after its last byte is written. Counts change only on cycles with `tick_i` high.
- R6: Rate-generator mode is operating mode 2 or 6. The counter decrements per tick. Its output is low for exactly the tick period in which the count is 1. The count is then reloaded, giving a period of N ticks.
- R7: Square-wave mode is operating mode 3 or 7. The counter steps down by 2 from the reload value with bit 0 cleared, and the count stays even. The output starts high and toggles every N/2 ticks.
- R8: In binary counting, a reload value of 0 gives a period of 65536 ticks.
- R9: In BCD counting, the count decrements as four decimal digits, and 0000 decrements to 9999.
- R10: The channels are independent. A control or data access to one channel does not change another channel's count or output.
- R11: After reset, every output is high, all latches and reload values are 0 and every channel is stopped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Count enable for all channels |
| wr_i | input | 1 | Byte write strobe |
| rd_i | input | 1 | Byte read strobe, advances the byte pointer |
| addr_i | input | 2 | 0 to 2 counter data ports, 3 control port |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data of the addressed channel, combinational |
| out_o | output | 3 | Per-channel timer outputs |

## Verification
The assertions check the following on every cycle:
- a control write clears the byte pointer and stops the channel with its output high;
- the latch captures the count on a latch command and otherwise holds;
- counts never move without a tick;
- a rate-generator low pulse never lasts longer than one tick;
- square-wave counts stay even.

Only the bench scenarios can show that:
- bytes land in the right half of the reload value;
- the pointer is shared between reads and writes;
- periods come out exactly N, N/2 and 65536 ticks;
- the BCD borrow chain gives the right digits.

// File: rtl/ivt_pkg.sv
package ivt_pkg;
  localparam int unsigned BYTE_W = 8;
  localparam int unsigned CNT_W  = 2 * BYTE_W;
  localparam int unsigned DIGITS = CNT_W / 4;

  typedef enum logic [1:0] {
    ACC_LATCH = 2'd0,
    ACC_LO    = 2'd1,
    ACC_HI    = 2'd2,
    ACC_LOHI  = 2'd3
  } acc_mode_e;

  // one step down, binary or packed BCD
  function automatic logic [CNT_W-1:0] cnt_dec(input logic [CNT_W-1:0] v, input logic bcd);
    logic [CNT_W-1:0] r;
    logic borrow;
    if (!bcd) return v - 1'b1;
    r = v;
    borrow = 1'b1;
    for (int d = 0; d < DIGITS; d++) begin
      if (borrow) begin
        if (v[d*4 +: 4] == 4'd0) begin
          r[d*4 +: 4] = 4'd9;
        end else begin
          r[d*4 +: 4] = v[d*4 +: 4] - 4'd1;
          borrow = 1'b0;
        end
      end
    end
    return r;
  endfunction
endpackage

// File: rtl/ivt_chan_regs.sv
module ivt_chan_regs
  import ivt_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cw_wr_i,
  input  logic [5:0]       cw_i,
  input  logic             wr_i,
  input  logic             rd_i,
  input  logic [BYTE_W-1:0] wdata_i,
  input  logic [CNT_W-1:0] count_i,
  output logic [CNT_W-1:0] reload_o,
  output logic             arm_o,
  output logic             stop_o,
  output logic [2:0]       mode_o,
  output logic             bcd_o,
  output logic [BYTE_W-1:0] rdata_o
);
  acc_mode_e        acc_q;
  logic [2:0]       mode_q;
  logic             bcd_q;
  logic             tog_q;
  logic [CNT_W-1:0] latch_q;
  logic [CNT_W-1:0] reload_q;
  logic             latch_cmd;

  assign latch_cmd = cw_wr_i && (cw_i[5:4] == ACC_LATCH);
  assign stop_o    = cw_wr_i && (cw_i[5:4] != ACC_LATCH);
  assign arm_o     = wr_i && ((acc_q != ACC_LOHI) || tog_q);
  assign reload_o  = reload_q;
  assign mode_o    = mode_q;
  assign bcd_o     = bcd_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q    <= ACC_LOHI;
      mode_q   <= '0;
      bcd_q    <= 1'b0;
      tog_q    <= 1'b0;
      latch_q  <= '0;
      reload_q <= '0;
    end else if (cw_wr_i) begin
      tog_q <= 1'b0;
      if (latch_cmd) begin
        latch_q <= count_i;
      end else begin
        acc_q  <= acc_mode_e'(cw_i[5:4]);
        mode_q <= cw_i[3:1];
        bcd_q  <= cw_i[0];
      end
    end else if (wr_i) begin
      case (acc_q)
        ACC_LO: reload_q[BYTE_W-1:0] <= wdata_i;
        ACC_HI: reload_q[CNT_W-1:BYTE_W] <= wdata_i;
        default: begin
          if (tog_q) reload_q[CNT_W-1:BYTE_W] <= wdata_i;
          else       reload_q[BYTE_W-1:0]     <= wdata_i;
          tog_q <= ~tog_q;
        end
      endcase
    end else if (rd_i && (acc_q == ACC_LOHI)) begin
      tog_q <= ~tog_q;
    end
  end

  always_comb begin
    case (acc_q)
      ACC_HI:   rdata_o = latch_q[CNT_W-1:BYTE_W];
      ACC_LOHI: rdata_o = tog_q ? latch_q[CNT_W-1:BYTE_W] : latch_q[BYTE_W-1:0];
      default:  rdata_o = latch_q[BYTE_W-1:0];
    endcase
  end

  AST_CW_CLEARS_PTR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cw_wr_i |=> !tog_q); // R3
  AST_LATCH_CAPTURE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    latch_cmd |=> latch_q == $past(count_i)); // R4
  AST_LATCH_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !latch_cmd |=> $stable(latch_q)); // R4
endmodule

// File: rtl/ivt_count_engine.sv
module ivt_count_engine
  import ivt_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             stop_i,
  input  logic             arm_i,
  input  logic [2:0]       mode_i,
  input  logic             bcd_i,
  input  logic [CNT_W-1:0] reload_i,
  output logic [CNT_W-1:0] count_o,
  output logic             out_o
);
  logic [CNT_W-1:0] count_q;
  logic             out_q;
  logic             pend_q;
  logic             run_q;
  logic             is_m2;
  logic             is_m3;
  logic [CNT_W-1:0] dec1;
  logic [CNT_W-1:0] dec2;
  logic [CNT_W-1:0] even_reload;

  assign is_m2       = (mode_i == 3'b010) || (mode_i == 3'b110);
  assign is_m3       = (mode_i == 3'b011) || (mode_i == 3'b111);
  assign dec1        = cnt_dec(count_q, bcd_i);
  assign dec2        = cnt_dec(dec1, bcd_i);
  assign even_reload = {reload_i[CNT_W-1:1], 1'b0};
  assign count_o     = count_q;
  assign out_o       = out_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      count_q <= '0;
      out_q   <= 1'b1;
      pend_q  <= 1'b0;
      run_q   <= 1'b0;
    end else if (stop_i) begin
      out_q  <= 1'b1;
      run_q  <= 1'b0;
      pend_q <= 1'b0;
    end else begin
      if (arm_i) pend_q <= 1'b1;
      if (tick_i) begin
        if (pend_q) begin
          count_q <= is_m3 ? even_reload : reload_i;
          out_q   <= 1'b1;
          run_q   <= 1'b1;
          pend_q  <= arm_i;
        end else if (run_q) begin
          if (is_m2) begin
            if (count_q == CNT_W'(1)) begin
              count_q <= reload_i;
              out_q   <= 1'b1;
            end else begin
              count_q <= dec1;
              if (count_q == CNT_W'(2)) out_q <= 1'b0;
            end
          end else if (is_m3) begin
            if (count_q == CNT_W'(2)) begin
              count_q <= even_reload;
              out_q   <= ~out_q;
            end else begin
              count_q <= dec2;
            end
          end
        end
      end
    end
  end

  AST_STOP_OUT_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_i |=> out_q && !run_q); // R1
  AST_NO_TICK_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick_i |=> $stable(count_q)); // R5
  AST_M2_SINGLE_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_q && is_m2 && !out_q && tick_i && !stop_i |=> out_q); // R6
  AST_M3_EVEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_q && is_m3 |-> !count_q[0]); // R7
endmodule

// File: rtl/interval_timer.sv
module interval_timer
  import ivt_pkg::*;
#(
  parameter int unsigned NUM_CH = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              wr_i,
  input  logic              rd_i,
  input  logic [1:0]        addr_i,
  input  logic [BYTE_W-1:0] wdata_i,
  output logic [BYTE_W-1:0] rdata_o,
  output logic [NUM_CH-1:0] out_o
);
  localparam logic [1:0] CTRL_ADDR = 2'd3;

  logic [NUM_CH-1:0]             cw_hit;
  logic [NUM_CH-1:0][BYTE_W-1:0] ch_rdata;

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    logic             sel;
    logic [CNT_W-1:0] count;
    logic [CNT_W-1:0] reload;
    logic             arm;
    logic             stop;
    logic [2:0]       mode;
    logic             bcd;

    assign sel       = (addr_i == 2'(g));
    assign cw_hit[g] = wr_i && (addr_i == CTRL_ADDR) && (wdata_i[7:6] == 2'(g));

    ivt_chan_regs u_regs (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .cw_wr_i (cw_hit[g]),
      .cw_i    (wdata_i[5:0]),
      .wr_i    (wr_i && sel),
      .rd_i    (rd_i && sel),
      .wdata_i (wdata_i),
      .count_i (count),
      .reload_o(reload),
      .arm_o   (arm),
      .stop_o  (stop),
      .mode_o  (mode),
      .bcd_o   (bcd),
      .rdata_o (ch_rdata[g])
    );

    ivt_count_engine u_eng (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .tick_i  (tick_i),
      .stop_i  (stop),
      .arm_i   (arm),
      .mode_i  (mode),
      .bcd_i   (bcd),
      .reload_i(reload),
      .count_o (count),
      .out_o   (out_o[g])
    );
  end

  always_comb begin
    rdata_o = '0;
    for (int i = 0; i < NUM_CH; i++)
      if (addr_i == 2'(i)) rdata_o = ch_rdata[i];
  end

  AST_CW_ONE_CHANNEL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(cw_hit)); // R10
  AST_NO_CW_NO_HIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_i != CTRL_ADDR) |-> cw_hit == '0); // R1
endmodule

// File: tb/interval_timer_tb_top.sv
module interval_timer_tb_top;
  localparam time CLK_PERIOD = 10ns;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       tick_i = 1'b0;
  logic       wr_i = 1'b0;
  logic       rd_i = 1'b0;
  logic [1:0] addr_i = '0;
  logic [7:0] wdata_i = '0;
  logic [7:0] rdata_o;
  logic [2:0] out_o;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  interval_timer dut_i (.*);

  task automatic chk(input string req, input int got, input int exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %0h expected %0h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk_i);
    addr_i = a; wdata_i = d; wr_i = 1'b1;
    @(negedge clk_i);
    wr_i = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] v);
    @(negedge clk_i);
    addr_i = a; rd_i = 1'b1;
    #1 v = rdata_o;
    @(negedge clk_i);
    rd_i = 1'b0;
  endtask

  task automatic ticks(input int n);
    @(negedge clk_i);
    tick_i = 1'b1;
    repeat (n) @(negedge clk_i);
    tick_i = 1'b0;
  endtask

  // latch then read low/high, channel in low-then-high access
  task automatic latch_cnt(input int ch, output int v);
    logic [7:0] lo, hi;
    wr(2'd3, 8'(ch << 6));
    rd(2'(ch), lo);
    rd(2'(ch), hi);
    v = {hi, lo};
  endtask

  task automatic t_reset;
    logic [7:0] v;
    chk("R11 outputs high", out_o, 3'b111);
    rd(2'd0, v);
    chk("R11 latch zero", v, 0);
  endtask

  task automatic t_rate_gen;
    int v;
    wr(3, 8'h34); wr(0, 8'h05); wr(0, 8'h00);
    ticks(1);
    latch_cnt(0, v); chk("R5 load on first tick", v, 5);
    repeat (10) @(negedge clk_i);
    latch_cnt(0, v); chk("R5 hold without tick", v, 5);
    ticks(3);
    chk("R6 high at count 2", out_o[0], 1);
    ticks(1);
    chk("R6 low at count 1", out_o[0], 0);
    ticks(1);
    chk("R6 high after reload", out_o[0], 1);
    latch_cnt(0, v); chk("R6 reloaded", v, 5);
    ticks(3); chk("R6 period high", out_o[0], 1);
    ticks(1); chk("R6 period low", out_o[0], 0);
    wr(3, 8'h34);
    chk("R1 control write drives out high", out_o[0], 1);
    ticks(5);
    chk("R1 stopped out stays high", out_o[0], 1);
    latch_cnt(0, v); chk("R1 stopped count held", v, 1);
  endtask

  task automatic t_square_indep;
    int v;
    wr(0, 8'h05); wr(0, 8'h00);
    ticks(1);
    wr(3, 8'h76);
    ticks(2);
    latch_cnt(0, v); chk("R10 ch0 unaffected by ch1 setup", v, 3);
    chk("R10 ch0 out", out_o[0], 1);
    wr(1, 8'h06); wr(1, 8'h00);
    ticks(1);
    chk("R7 starts high", out_o[1], 1);
    ticks(2); chk("R7 high half", out_o[1], 1);
    ticks(1); chk("R7 toggles low", out_o[1], 0);
    ticks(2); chk("R7 low half", out_o[1], 0);
    ticks(1); chk("R7 toggles high", out_o[1], 1);
    latch_cnt(1, v); chk("R7 even reload", v, 6);
    wr(3, 8'hF4);
    chk("R1 select 3 leaves outputs", out_o[1], 1);
    ticks(1);
    latch_cnt(1, v); chk("R1 select 3 ignored, ch1 counting", v, 4);
  endtask

  task automatic t_byte_modes;
    logic [7:0] b;
    wr(3, 8'h94); wr(2, 8'h34);
    wr(3, 8'hA4); wr(2, 8'h12);
    ticks(1);
    wr(3, 8'h80);
    rd(2, b); chk("R4 high-only read", b, 8'h12);
    rd(2, b); chk("R4 high-only read repeats", b, 8'h12);
    wr(3, 8'h94);
    rd(2, b); chk("R4 low-only read of latch", b, 8'h34);
    wr(2, 8'h56);
    ticks(1);
    wr(3, 8'h80);
    rd(2, b); chk("R2 low byte replaced", b, 8'h56);
    wr(3, 8'hA4);
    rd(2, b); chk("R2 high byte kept", b, 8'h12);
  endtask

  task automatic t_pointer;
    int v;
    logic [7:0] b;
    wr(3, 8'h34); wr(0, 8'h10);
    wr(3, 8'h34); wr(0, 8'h20); wr(0, 8'h00);
    ticks(1);
    latch_cnt(0, v); chk("R3 control write restarts at low byte", v, 16'h0020);
    wr(3, 8'h00);
    rd(0, b); chk("R3 first read low", b, 8'h20);
    wr(0, 8'h01);
    ticks(1);
    latch_cnt(0, v); chk("R3 read and write share pointer", v, 16'h0120);
  endtask

  task automatic t_zero_reload;
    int v;
    wr(3, 8'h34); wr(0, 8'h00); wr(0, 8'h00);
    ticks(1); ticks(1);
    latch_cnt(0, v); chk("R8 zero wraps to FFFF", v, 16'hFFFF);
    ticks(65533); chk("R8 still high", out_o[0], 1);
    ticks(1); chk("R8 low after 65536 ticks", out_o[0], 0);
  endtask

  task automatic t_bcd;
    int v;
    wr(3, 8'hB5); wr(2, 8'h00); wr(2, 8'h00);
    ticks(1); ticks(1);
    latch_cnt(2, v); chk("R9 BCD 0000 to 9999", v, 16'h9999);
    ticks(8999);
    latch_cnt(2, v); chk("R9 BCD reaches 1000", v, 16'h1000);
    ticks(1);
    latch_cnt(2, v); chk("R9 BCD borrow chain", v, 16'h0999);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    t_reset();
    t_rate_gen();
    t_square_indep();
    t_byte_modes();
    t_pointer();
    t_zero_reload();
    t_bcd();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule